// File: doc/BRIEF.md
# Floating-Point Result Normalize, Round and Pack Unit

This unit is the last stage of a floating-point datapath. An arithmetic stage hands it an unpacked result. That result has a 56-bit mantissa with a carry position at bit 55 and the hidden leading one at bit 54. It also has a signed exponent, a sign flag and a precision code. The unit turns this into the words kept in memory, plus a trap code that the caller acts on.

Real results use a sign-magnitude layout with an excess-256 exponent, in two, three or four 16-bit words. Integer results are 32-bit two's complement, carried on the top two words. The unit normalizes the mantissa one bit per clock, then rounds, masks, packs and classifies the result. A start/done handshake covers the variable number of normalization cycles.

Top module: `fpnrp_pack_unit`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. Once accepted, `busy` is high from the next cycle until the result is ready. `done` is a one-cycle pulse. It is raised two clock edges after the accepting edge, plus one edge per normalization shift. A `start` seen while `busy` is high is ignored and does not change the result.
- R2: After reset, `done`, `busy`, `pk_words` and `pk_trap` are all zero. `pk_words` and `pk_trap` change only in the cycle where `done` is high, and hold their values otherwise.
- R3: A zero mantissa gives all-zero words and trap code 0 (none) for every precision, sign and exponent, with no normalization shift.
- R4: For a real precision, if mantissa bit 55 is set, the mantissa is shifted right once and the exponent is incremented. This costs one shift.
- R5: For a real precision, a nonzero mantissa with bits 55 and 54 both clear is shifted left one bit per cycle, decrementing the exponent each time, until bit 54 is set. This takes at most 54 shifts.
- R6: Real packing, with word 0 in `pk_words[63:48]`: bit 15 of word 0 is the sign; bits 14..6 are (exponent + 256) mod 512; bits 5..0 are mantissa bits 53..48. Words 1, 2 and 3 hold mantissa bits 47..32, 31..16 and 15..0.
- R7: Rounding adds one at mantissa bit 31 for two words, bit 15 for three words and bit 0 for four words. If this carries into bit 55, only the exponent is incremented, and the kept mantissa bits stay as the addition left them.
- R8: Mantissa bits below the kept range are cleared. Two words keep bits 53..32, so words 2 and 3 are zero. Three words keep bits 53..16, so word 3 is zero.
- R9: Trap code 1 (float underflow) is raised when the final exponent is below -256, or when it equals -256 and the kept mantissa bits are all zero.
- R10: Trap code 2 (float overflow) is raised when the final exponent is above +255 and underflow does not apply. Trap code 0 means no trap.
- R11: Trap code 3 (integer overflow) is raised, with all-zero words, when the exponent is at least 15 for the 16-bit integer precision, or at least 31 for the 32-bit one.
- R12: Otherwise an integer result is the mantissa shifted right by (54 - exponent), masked to 16 or 32 bits, and negated if the sign is set. It is placed as 32-bit two's complement in `pk_words[63:32]`, with `pk_words[31:0]` zero, and is not normalized. Precision codes: 0 = 16-bit integer, 1 = 32-bit integer, 2 = two-word real, 3 = three-word real, 4 = four-word real. Codes 5 to 7 act as four-word real.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to pack the operand on the inputs |
| mant_in | input | 56 | Unpacked mantissa: carry at bit 55, hidden one at bit 54 |
| exp_in | input | EXP_W | Unbiased exponent, two's complement |
| neg_in | input | 1 | Sign of the result, 1 = negative |
| prec_in | input | 3 | Precision code (see R12) |
| busy | output | 1 | Normalization in progress |
| done | output | 1 | One-cycle pulse: a new result is on the outputs |
| pk_words | output | 64 | Packed words, word 0 in the top 16 bits |
| pk_trap | output | 2 | Trap code: 0 none, 1 float underflow, 2 float overflow, 3 integer overflow |

## Verification
The bench builds the unit with its default exponent width of 12 bits. This width reaches exponents well past both float trap limits. It also reaches a full 54-step normalization that starts near -256 and ends deep in underflow, without the exponent register wrapping. With these settings, the exact boundary exponents -257, -256, +255 and +256 can all be tested, as can the integer limits 14/15 and 30/31. So can a rounding carry that lifts +255 into overflow.

// File: rtl/fpnrp_pkg.sv
package fpnrp_pkg;

  localparam int MANT_W      = 56;
  localparam int CARRY_POS   = 55;
  localparam int IMPL_POS    = 54;
  localparam int FRAC_BITS   = 54;
  localparam int WORD_W      = 16;
  localparam int NUM_WORDS   = 4;
  localparam int OUT_W       = WORD_W * NUM_WORDS;
  localparam int HEAD_BITS   = 6;
  localparam int BEXP_W      = 9;
  localparam int EXP_BIAS    = 256;
  localparam int EXP_LO      = -256;
  localparam int EXP_HI      = 255;
  localparam int SHIFT_CNT_W = $clog2(FRAC_BITS + 1);

  localparam logic [2:0] PREC_I16 = 3'd0;
  localparam logic [2:0] PREC_I32 = 3'd1;
  localparam logic [2:0] PREC_R2  = 3'd2;
  localparam logic [2:0] PREC_R3  = 3'd3;

  localparam logic [1:0] TRAP_NONE  = 2'd0;
  localparam logic [1:0] TRAP_FUNDR = 2'd1;
  localparam logic [1:0] TRAP_FOVR  = 2'd2;
  localparam logic [1:0] TRAP_IOVR  = 2'd3;

  function automatic logic prec_is_int(input logic [2:0] p);
    return (p == PREC_I16) || (p == PREC_I32);
  endfunction

  // lowest mantissa bit kept for a real precision
  function automatic int kept_low(input logic [2:0] p);
    case (p)
      PREC_R2: return 32;
      PREC_R3: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [MANT_W-1:0] round_inc(input logic [2:0] p);
    int lo;
    lo = kept_low(p);
    if (lo == 0) return MANT_W'(1);
    return MANT_W'(1) << (lo - 1);
  endfunction

  function automatic logic [MANT_W-1:0] keep_mask(input logic [2:0] p);
    logic [MANT_W-1:0] frac_ones;
    frac_ones = (MANT_W'(1) << FRAC_BITS) - MANT_W'(1);
    return frac_ones & ~((MANT_W'(1) << kept_low(p)) - MANT_W'(1));
  endfunction

endpackage

// File: rtl/fpnrp_normalizer.sv
module fpnrp_normalizer
  import fpnrp_pkg::*;
#(
  parameter int EXP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic                    freeze_i,
  output logic [MANT_W-1:0]       mant_q,
  output logic signed [EXP_W-1:0] exp_q,
  output logic                    settled
);

  logic                   frz_q;
  logic [SHIFT_CNT_W-1:0] shift_cnt;
  logic                   is_zero;
  logic                   do_right;
  logic                   do_left;

  assign is_zero  = (mant_q == '0);
  assign do_right = step && !frz_q && mant_q[CARRY_POS];
  assign do_left  = step && !frz_q && !is_zero && !mant_q[CARRY_POS] && !mant_q[IMPL_POS];
  assign settled  = frz_q || is_zero || (mant_q[IMPL_POS] && !mant_q[CARRY_POS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mant_q    <= '0;
      exp_q     <= '0;
      frz_q     <= 1'b0;
      shift_cnt <= '0;
    end else if (load) begin
      mant_q    <= mant_i;
      exp_q     <= exp_i;
      frz_q     <= freeze_i;
      shift_cnt <= '0;
    end else if (do_right) begin
      mant_q <= mant_q >> 1;
      exp_q  <= exp_q + EXP_W'(1);
    end else if (do_left) begin
      mant_q    <= mant_q << 1;
      exp_q     <= exp_q - EXP_W'(1);
      shift_cnt <= shift_cnt + SHIFT_CNT_W'(1);
    end
  end

  // R5: left shifts never exceed the mantissa fraction width
  p_shift_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_cnt <= SHIFT_CNT_W'(FRAC_BITS));

  // R4: one right shift lands the leading one on the hidden position
  p_right_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_right |=> (exp_q == $past(exp_q) + EXP_W'(1)) && mant_q[IMPL_POS] && !mant_q[CARRY_POS]);

  // R5: each left shift lowers the exponent by one
  p_left_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_left |=> exp_q == $past(exp_q) - EXP_W'(1));

endmodule

// File: rtl/fpnrp_real_pack.sv
module fpnrp_real_pack
  import fpnrp_pkg::*;
#(
  parameter int EXP_W = 12
) (
  input  logic [MANT_W-1:0]       mant_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic                    neg_i,
  input  logic [2:0]              prec_i,
  output logic [OUT_W-1:0]        words_o,
  output logic [1:0]              trap_o,
  output logic                    rnd_carry
);

  logic [MANT_W-1:0]       rsum;
  logic [MANT_W-1:0]       kept;
  logic signed [EXP_W-1:0] e_fin;
  logic [BEXP_W-1:0]       bexp;
  logic                    frac_zero;

  always_comb begin
    rsum      = mant_i + round_inc(prec_i);
    rnd_carry = rsum[CARRY_POS];
    e_fin     = exp_i + (rnd_carry ? EXP_W'(1) : EXP_W'(0));
    kept      = rsum & keep_mask(prec_i);
    bexp      = BEXP_W'(e_fin + EXP_W'(EXP_BIAS));
    frac_zero = (kept == '0);
    if (e_fin < EXP_LO || (e_fin == EXP_LO && frac_zero)) trap_o = TRAP_FUNDR;
    else if (e_fin > EXP_HI)                              trap_o = TRAP_FOVR;
    else                                                  trap_o = TRAP_NONE;
  end

  assign words_o[OUT_W-1 -: WORD_W] = {neg_i, bexp, kept[FRAC_BITS-1 -: HEAD_BITS]};

  for (genvar g = 1; g < NUM_WORDS; g++) begin : g_tail
    assign words_o[(NUM_WORDS-1-g)*WORD_W +: WORD_W] = kept[(NUM_WORDS-1-g)*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/fpnrp_int_pack.sv
module fpnrp_int_pack
  import fpnrp_pkg::*;
#(
  parameter int EXP_W = 12
) (
  input  logic [MANT_W-1:0]       mant_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic                    neg_i,
  input  logic                    wide_i,
  output logic [OUT_W-1:0]        words_o,
  output logic [1:0]              trap_o,
  output logic                    too_big
);

  localparam int SH_W = EXP_W + 1;

  logic [SH_W-1:0]   sh;
  logic [MANT_W-1:0] mag_full;
  logic [31:0]       mag32;
  logic [31:0]       val32;

  always_comb begin
    too_big  = exp_i >= (wide_i ? 31 : 15);
    sh       = SH_W'(FRAC_BITS) - {exp_i[EXP_W-1], exp_i};
    mag_full = mant_i >> sh;
    mag32    = 32'(mag_full) & (wide_i ? 32'hFFFF_FFFF : 32'h0000_FFFF);
    val32    = neg_i ? (32'd0 - mag32) : mag32;
    words_o  = too_big ? '0 : {val32, 32'd0};
    trap_o   = too_big ? TRAP_IOVR : TRAP_NONE;
  end

endmodule

// File: rtl/fpnrp_pack_unit.sv
module fpnrp_pack_unit
  import fpnrp_pkg::*;
#(
  parameter int EXP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [55:0]      mant_in,
  input  logic [EXP_W-1:0] exp_in,
  input  logic             neg_in,
  input  logic [2:0]       prec_in,
  output logic             busy,
  output logic             done,
  output logic [63:0]      pk_words,
  output logic [1:0]       pk_trap
);

  typedef enum logic {ST_IDLE, ST_NORM} state_e;

  state_e                  state;
  logic [2:0]              prec_q;
  logic                    neg_q;
  logic                    accept;
  logic                    finish;
  logic                    settled;
  logic [MANT_W-1:0]       mant_q;
  logic signed [EXP_W-1:0] exp_q;
  logic [OUT_W-1:0]        real_words, int_words, sel_words;
  logic [1:0]              real_trap, int_trap, sel_trap;
  logic                    rnd_carry;
  logic                    int_too_big;

  assign accept = start && (state == ST_IDLE);
  assign finish = (state == ST_NORM) && settled;
  assign busy   = (state == ST_NORM);

  fpnrp_normalizer #(.EXP_W(EXP_W)) u_norm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (busy),
    .mant_i   (mant_in),
    .exp_i    ($signed(exp_in)),
    .freeze_i (prec_is_int(prec_in)),
    .mant_q   (mant_q),
    .exp_q    (exp_q),
    .settled  (settled)
  );

  fpnrp_real_pack #(.EXP_W(EXP_W)) u_real (
    .mant_i    (mant_q),
    .exp_i     (exp_q),
    .neg_i     (neg_q),
    .prec_i    (prec_q),
    .words_o   (real_words),
    .trap_o    (real_trap),
    .rnd_carry (rnd_carry)
  );

  fpnrp_int_pack #(.EXP_W(EXP_W)) u_int (
    .mant_i  (mant_q),
    .exp_i   (exp_q),
    .neg_i   (neg_q),
    .wide_i  (prec_q == PREC_I32),
    .words_o (int_words),
    .trap_o  (int_trap),
    .too_big (int_too_big)
  );

  always_comb begin
    if (mant_q == '0) begin
      sel_words = '0;
      sel_trap  = TRAP_NONE;
    end else if (prec_is_int(prec_q)) begin
      sel_words = int_words;
      sel_trap  = int_trap;
    end else begin
      sel_words = real_words;
      sel_trap  = real_trap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      prec_q   <= '0;
      neg_q    <= 1'b0;
      done     <= 1'b0;
      pk_words <= '0;
      pk_trap  <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        state  <= ST_NORM;
        prec_q <= prec_in;
        neg_q  <= neg_in;
      end else if (finish) begin
        state    <= ST_IDLE;
        pk_words <= sel_words;
        pk_trap  <= sel_trap;
      end
    end
  end

  // R1: accepted start raises busy on the next cycle
  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R1: done lasts one cycle
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: results move only with done
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pk_words) && $stable(pk_trap));

  // R3: zero mantissa gives a clean zero
  p_zero_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && mant_q == '0) |=> (pk_words == '0) && (pk_trap == TRAP_NONE));

  // R12: integer results skip normalization
  p_int_direct_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && prec_is_int(prec_in)) |=> finish);

  // R11: integer overflow always comes with zero words
  p_int_ovf_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && prec_is_int(prec_q) && int_too_big && mant_q != '0) |=>
      (pk_trap == TRAP_IOVR) && (pk_words == '0));

  // R7: a rounding carry with a modest exponent never reports overflow
  p_round_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !prec_is_int(prec_q) && rnd_carry && exp_q < 0 && exp_q > -200) |=>
      pk_trap == TRAP_NONE);

endmodule

// File: tb/fpnrp_pack_unit_test.sv
module fpnrp_pack_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [55:0] mant_in;
  logic [11:0] exp_in;
  logic        neg_in;
  logic [2:0]  prec_in;
  logic        busy, done;
  logic [63:0] pk_words;
  logic [1:0]  pk_trap;

  always #4 clk = ~clk;

  fpnrp_pack_unit #(.EXP_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mant_in(mant_in), .exp_in(exp_in),
    .neg_in(neg_in), .prec_in(prec_in), .busy(busy), .done(done),
    .pk_words(pk_words), .pk_trap(pk_trap)
  );

  typedef struct {
    logic [63:0] w;
    logic [1:0]  t;
    int          lat;
    int          c0;
    string       tag;
  } sb_item_t;

  sb_item_t    sbq[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [63:0] last_w = '0;
  logic [1:0]  last_t = '0;
  bit          moved = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input logic [55:0] m, input int e, input bit n, input int p,
                       output logic [63:0] w, output logic [1:0] t, output int lat);
    logic [55:0] mm;
    logic [55:0] mag;
    logic [31:0] v;
    logic [15:0] f1, f2, f3;
    logic [5:0]  head;
    int          ee, sh, rb;
    lat = 2;
    w = '0;
    t = 2'd0;
    if (m == '0) return;
    if (p < 2) begin
      if (e >= ((p == 0) ? 15 : 31)) begin
        t = 2'd3;
        return;
      end
      sh = 54 - e;
      mag = (sh >= 56) ? 56'd0 : (m >> sh);
      v = (p == 0) ? {16'd0, mag[15:0]} : mag[31:0];
      if (n) v = -v;
      w = {v, 32'd0};
      return;
    end
    mm = m;
    ee = e;
    if (mm[55]) begin
      mm = mm >> 1; ee++; lat++;
    end else begin
      while (!mm[54]) begin
        mm = mm << 1; ee--; lat++;
      end
    end
    rb = (p == 2) ? 31 : (p == 3) ? 15 : 0;
    mm = mm + (56'd1 << rb);
    if (mm[55]) ee++;
    head = mm[53:48];
    f1 = mm[47:32];
    f2 = (p == 2) ? 16'd0 : mm[31:16];
    f3 = (p == 4) ? mm[15:0] : 16'd0;
    w = {n, 9'(ee + 256), head, f1, f2, f3};
    if (ee < -256 || (ee == -256 && head == 0 && f1 == 0 && f2 == 0 && f3 == 0)) t = 2'd1;
    else if (ee > 255) t = 2'd2;
  endtask

  // monitor: pops the scoreboard when a result appears
  always @(negedge clk) begin
    sb_item_t item;
    if (rst_n === 1'b1) begin
      if (done) begin
        if (sbq.size() == 0) begin
          check("R1", "unexpected done", 64'd1, 64'd0);
        end else begin
          item = sbq.pop_front();
          check(item.tag, "words", pk_words, item.w);
          check(item.tag, "trap", 64'(pk_trap), 64'(item.t));
          check("R1", "latency", 64'(cyc - item.c0), 64'(item.lat));
          check("R2", "outputs moved between done pulses", 64'(moved), 64'd0);
        end
        moved  = 0;
        last_w = pk_words;
        last_t = pk_trap;
      end else if (pk_words !== last_w || pk_trap !== last_t) begin
        moved = 1;
      end
    end
  end

  task automatic run_op(input logic [55:0] m, input int e, input bit n, input int p,
                        input string tag, input bit poke = 0);
    sb_item_t it;
    @(negedge clk);
    mant_in = m; exp_in = 12'(e); neg_in = n; prec_in = 3'(p); start = 1'b1;
    model(m, e, n, p, it.w, it.t, it.lat);
    it.c0 = cyc;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    if (poke) begin
      // R1: second start while busy must be ignored
      check("R1", "busy while normalizing", 64'(busy), 64'd1);
      mant_in = 56'h40_0000_0000_0000; exp_in = 12'd7; prec_in = 3'd2; neg_in = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mant_in = '0; exp_in = '0; neg_in = 1'b0; prec_in = '0;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2", "reset done", 64'(done), 64'd0);
    check("R2", "reset busy", 64'(busy), 64'd0);
    check("R2", "reset words", pk_words, 64'd0);
    check("R2", "reset trap", 64'(pk_trap), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 R8: normalized operand at every real width
    run_op(56'h4B_C3A5_96E1_0F7D, 3, 1, 2, "R6 R8 two-word");
    run_op(56'h4B_C3A5_96E1_0F7D, 3, 1, 3, "R6 R8 three-word");
    run_op(56'h4B_C3A5_96E1_0F7D, -9, 0, 4, "R6 four-word");
    // R4: carry position set
    run_op(56'hC1_2345_6789_ABCD, 10, 0, 4, "R4 right shift");
    // R5: worst-case left normalization, with an ignored start (R1)
    run_op(56'h00_0000_0000_0001, 100, 0, 4, "R5 54 shifts", 1);
    run_op(56'h00_0100_0000_0000, 0, 1, 2, "R5 14 shifts");
    // R7: rounding carries and a plain round-up
    run_op(56'h7F_FFFF_FFFF_FFFF, 5, 0, 2, "R7 carry two-word");
    run_op(56'h7F_FFFF_FFFF_FFFF, 5, 1, 3, "R7 carry three-word");
    run_op(56'h7F_FFFF_FFFF_FFFF, 5, 0, 4, "R7 carry four-word");
    run_op(56'h40_0000_8000_0000, 1, 0, 2, "R7 round up");
    // R3: zeros
    run_op(56'd0, 77, 1, 2, "R3 negative zero");
    run_op(56'd0, 40, 0, 0, "R3 integer zero");
    // R9: underflow boundaries
    run_op(56'h40_0000_0000_0000, -256, 0, 2, "R9 looks like zero");
    run_op(56'h40_0000_0000_0000, -257, 0, 4, "R9 below range");
    run_op(56'h40_0001_0000_0000, -256, 0, 2, "R9 smallest legal");
    run_op(56'h40_0000_0001_0000, -256, 0, 2, "R9 R8 masked away");
    run_op(56'h40_0000_0001_0000, -256, 0, 3, "R9 R8 kept");
    run_op(56'h00_0000_0000_0001, -250, 1, 4, "R9 R5 shifted under");
    // R10: overflow boundaries
    run_op(56'h4B_C3A5_96E1_0F7D, 255, 0, 4, "R10 largest legal");
    run_op(56'h4B_C3A5_96E1_0F7D, 256, 1, 4, "R10 above range");
    run_op(56'h7F_FFFF_FFFF_FFFF, 255, 0, 2, "R10 R7 rounded over");
    // R11 R12: integers
    run_op(56'h40_0000_0000_0000, 14, 0, 0, "R12 int16 positive");
    run_op(56'h40_0000_0000_0000, 14, 1, 0, "R12 int16 negative");
    run_op(56'h40_0000_0000_0000, 15, 0, 0, "R11 int16 limit");
    run_op(56'h5A_5A5A_5A5A_5A5A, 30, 1, 1, "R12 int32 negative");
    run_op(56'h5A_5A5A_5A5A_5A5A, 31, 0, 1, "R11 int32 limit");
    run_op(56'h5A_5A5A_5A5A_5A5A, -3, 0, 0, "R12 tiny integer");

    repeat (5) @(negedge clk);
    check("R1", "leftover expected results", 64'(sbq.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule